// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the clocked control path of a common-I/O pipelined burst cache RAM with byte-lane writes. On every rising clock edge it samples three chip selects, two address strobes (a processor strobe and a controller strobe), an advance input and the write controls. From these it picks one action: deselect, start a read burst, start a write burst, continue a burst at the next address, or hold a burst at its current address. It drives a behavioural word array with one write enable per byte lane. It also gates the output enable of a bidirectional data bus, which is modelled as separate input, output and enable signals.

A new access loads the upper address bits into a register and the two low bits into a wraparound burst counter. Later cycles with both strobes inactive either step the counter (advance low) or keep it (advance high). The step follows a linear or an interleaved order, chosen by a mode input. Read data leaves a register one cycle after its address is taken. The output enable input acts combinationally.

Top module: `burst_sram_ctrl`

## Requirements
- R1: The part is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe edge while it is not selected deselects it. Nothing is written, and `dq_oe` is 0 after that edge.
- R2: An access started by `adsp_n`=0 with `ce1_n`=0 is always a read. Write controls sampled on that edge are ignored and leave the array unchanged.
- R3: In a burst started by `adsp_n`, write controls that are active on a later edge write `dq_in` on that edge. With `adv_n`=1 the write goes to the current address; with `adv_n`=0 it goes to the next one.
- R4: An access started by `adsc_n`=0 (with `adsp_n`=1, or with `ce1_n`=1) writes on that same edge when the write controls request a write, and reads otherwise. When both strobes are low and `ce1_n`=0, only the processor strobe counts.
- R5: `gw_n`=0 writes all four bytes, whatever `bwe_n` and `bw_n` are. Otherwise a byte lane is written only when `bwe_n`=0 and its `bw_n` bit is 0. Bit i of `bw_n` controls `dq_in[8i+7:8i]`. With `bwe_n`=1 and `gw_n`=1 nothing is written.
- R6: `oe_n` acts without a clock. `dq_oe` is 0 whenever `oe_n`=1, and it follows `oe_n` at once while read data is held.
- R7: During a cycle that writes, `dq_oe` is 0 whatever `oe_n` is.
- R8: Read data for an address taken on edge k appears on `dq_out`, with `dq_oe`=1 (when `oe_n`=0), from edge k until edge k+1.
- R9: With `mode`=0, the n-th access of a burst uses low address bits (start + n) mod 4.
- R10: With `mode`=1, the n-th access of a burst uses low address bits start XOR n.
- R11: With both strobes inactive and the part in a burst, `adv_n`=0 moves to the next burst address and `adv_n`=1 repeats the current one. Either can read or write.
- R12: While `zz`=1, every edge acts as a deselect. No write takes place, `dq_oe` is 0 after the edge, and the array keeps its contents.
- R13: After reset, `dq_oe` is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | Chip select, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | DATA_W/8 | Per-lane byte write selects, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| zz | input | 1 | Sleep request, active high |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Data bus, inbound half |
| dq_out | output | DATA_W | Data bus, outbound half |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The assertions assume that the control inputs are never X and never change close to a clock edge. They also assume that `oe_n` changes only between edges. The bench meets these conditions by driving every input half a nanosecond after the falling edge. It samples results on the falling edge, so each registered read is seen exactly once. The bench only reads back addresses it has written before, so the array never returns unknown data that the assertions or the scoreboard would have to excuse.

// File: rtl/burst_sram_ctrl.sv
`timescale 1ns/1ps
module burst_sram_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce1_n,
  input  logic                ce2,
  input  logic                ce3_n,
  input  logic                adsp_n,
  input  logic                adsc_n,
  input  logic                adv_n,
  input  logic                gw_n,
  input  logic                bwe_n,
  input  logic [DATA_W/8-1:0] bw_n,
  input  logic                oe_n,
  input  logic                zz,
  input  logic                mode,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   dq_in,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe
);
  localparam int NB    = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              active, rd_vld;
  logic [1:0]        base, cnt, nxt_cnt, burst_lo;
  logic [ADDR_W-3:0] hi_q;
  logic [ADDR_W-1:0] eff_addr;
  logic [NB-1:0]     lane_m, we;

  wire sel      = !ce1_n && ce2 && !ce3_n;
  wire p_start  = !adsp_n && !ce1_n;
  wire c_start  = !adsc_n && !p_start;
  wire start    = p_start || c_start;
  wire wr_ask   = !gw_n || (!bwe_n && !(&bw_n));
  wire begin_ac = !zz && start && sel;
  wire cont     = !zz && !start && active;
  wire do_wr    = ((begin_ac && c_start) || cont) && wr_ask;
  wire do_rd    = (begin_ac && (p_start || !wr_ask)) || (cont && !wr_ask);

  assign lane_m   = !gw_n ? {NB{1'b1}} : (bwe_n ? {NB{1'b0}} : ~bw_n);
  assign we       = do_wr ? lane_m : {NB{1'b0}};
  assign nxt_cnt  = cnt + {1'b0, !adv_n};
  assign burst_lo = mode ? (base ^ nxt_cnt) : (base + nxt_cnt);
  assign eff_addr = begin_ac ? addr : {hi_q, burst_lo};
  assign dq_out   = rd_q;
  assign dq_oe    = rd_vld && !oe_n && !do_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      rd_vld <= 1'b0;
      cnt    <= '0;
      base   <= '0;
      hi_q   <= '0;
    end else begin
      rd_vld <= do_rd;
      if (zz) begin
        active <= 1'b0;
      end else if (start) begin
        active <= sel;
        if (sel) begin
          hi_q <= addr[ADDR_W-1:2];
          base <= addr[1:0];
          cnt  <= '0;
        end
      end else if (cont) begin
        cnt <= nxt_cnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++)
      if (we[i]) mem[eff_addr][8*i +: 8] <= dq_in[8*i +: 8];
    if (do_rd) rd_q <= mem[eff_addr];
  end

  p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && start && !sel) |=> !dq_oe);
  p_adsp_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && p_start && sel) |=> rd_vld);
  p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);
  p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we != '0) |=> !rd_vld);
  p_suspend_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && adv_n) |=> $stable(cnt));
  p_sleep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> (!dq_oe && !active));
endmodule

// File: tb/burst_sram_ctrl_bench.sv
`timescale 1ns/1ps
module burst_sram_ctrl_bench;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0;
  logic ce1_n = 1, ce2 = 1, ce3_n = 0, adsp_n = 1, adsc_n = 1, adv_n = 1;
  logic gw_n = 1, bwe_n = 1, oe_n = 0, zz = 0, mode = 0;
  logic [3:0] bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [31:0] dq_in = '0, dq_out;
  logic dq_oe;
  int n_tot = 0, n_bad = 0;
  logic [31:0] rm [1<<AW];
  logic [31:0] exp_w [$];
  string exp_r [$];

  always #2 clk = ~clk;

  burst_sram_ctrl #(.ADDR_W(AW), .DATA_W(32)) u_burst_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .zz(zz), .mode(mode),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [1:0] seq(input logic [1:0] b, input logic [1:0] n, input logic md);
    return md ? (b ^ n) : (b + n);
  endfunction

  function automatic void rwrite(input int a, input logic [31:0] d, input logic gw, input logic bwe, input logic [3:0] bw);
    for (int i = 0; i < 4; i++)
      if (!gw || (!bwe && !bw[i])) rm[a][8*i +: 8] = d[8*i +: 8];
  endfunction

  task automatic cyc(input logic ps, input logic cs, input logic adv, input logic gw,
                     input logic bwe, input logic [3:0] bw, input int a, input logic [31:0] d);
    #0.5;
    ce1_n = 0; adsp_n = ps; adsc_n = cs; adv_n = adv; gw_n = gw; bwe_n = bwe;
    bw_n = bw; addr = AW'(a); dq_in = d;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    #0.5;
    ce1_n = 1; adsp_n = 1; adsc_n = 0; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd1(input int a, input string rq);
    exp_w.push_back(rm[a]); exp_r.push_back(rq);
    cyc(1, 0, 1, 1, 1, 4'hF, a, 32'h0);
    idle();
  endtask

  always @(negedge clk) begin
    if (rst_n && dq_oe) begin
      if (exp_w.size() == 0) chk(0, "R8 unexpected read", dq_out, 32'h0);
      else begin
        automatic logic [31:0] w = exp_w.pop_front();
        automatic string r = exp_r.pop_front();
        chk(dq_out === w, r, dq_out, w);
      end
    end
  end

  initial begin
    #150000;
    chk(0, "watchdog", 32'h0, 32'h0);
    $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(dq_oe == 0, "R13 reset", 32'(dq_oe), 32'h0);

    // R4 R5: controller-strobe global writes fill words 0..15
    for (int i = 0; i < 16; i++) begin
      automatic logic [31:0] d = 32'hC0DE0000 | (32'(i) * 32'h00010203);
      cyc(1, 0, 1, 0, 1, 4'hF, i, d);
      rwrite(i, d, 0, 1, 4'hF);
      if (i == 0) chk(dq_oe == 0, "R7 write quiet", 32'(dq_oe), 32'h0);
    end
    idle();

    // R9 R2 R8 R11: linear burst from 5 (5,6,7,4), writes ignored at start
    mode = 0;
    exp_w.push_back(rm[5]); exp_r.push_back("R2 adsp start read");
    cyc(0, 1, 1, 0, 1, 4'hF, 5, 32'hDEADBEEF);
    for (int n = 1; n < 4; n++) begin
      exp_w.push_back(rm[4 + seq(2'd1, 2'(n), 0)]); exp_r.push_back("R9 linear");
      cyc(1, 1, 0, 1, 1, 4'hF, 0, 32'h0);
    end
    idle();
    rd1(5, "R2 write ignored");

    // R10: interleaved burst from 10 (10,11,8,9)
    mode = 1;
    exp_w.push_back(rm[10]); exp_r.push_back("R10 start");
    cyc(0, 1, 1, 1, 1, 4'hF, 10, 32'h0);
    for (int n = 1; n < 4; n++) begin
      exp_w.push_back(rm[8 + seq(2'd2, 2'(n), 1)]); exp_r.push_back("R10 interleaved");
      cyc(1, 1, 0, 1, 1, 4'hF, 0, 32'h0);
    end
    idle();
    mode = 0;

    // R11: suspend repeats, then advance
    exp_w.push_back(rm[13]); exp_r.push_back("R11 start");
    cyc(0, 1, 1, 1, 1, 4'hF, 13, 32'h0);
    exp_w.push_back(rm[13]); exp_r.push_back("R11 suspend");
    cyc(1, 1, 1, 1, 1, 4'hF, 0, 32'h0);
    exp_w.push_back(rm[14]); exp_r.push_back("R11 advance");
    cyc(1, 1, 0, 1, 1, 4'hF, 0, 32'h0);
    idle();

    // R3 R5 R7: processor-started burst, byte write on suspend, global write on continue
    exp_w.push_back(rm[4]); exp_r.push_back("R3 start read");
    cyc(0, 1, 1, 0, 1, 4'hF, 4, 32'hBADBAD00);
    cyc(1, 1, 1, 1, 0, 4'b1010, 0, 32'h11223344);
    rwrite(4, 32'h11223344, 1, 0, 4'b1010);
    chk(dq_oe == 0, "R7 write forces high-Z", 32'(dq_oe), 32'h0);
    cyc(1, 1, 0, 0, 1, 4'hF, 0, 32'h55667788);
    rwrite(5, 32'h55667788, 0, 1, 4'hF);
    idle();
    rd1(4, "R3 suspend byte write");
    rd1(5, "R3 continue write");

    // R5 R4: bwe_n high means no write, so it reads
    exp_w.push_back(rm[6]); exp_r.push_back("R4 adsc read");
    cyc(1, 0, 1, 1, 1, 4'h0, 6, 32'hFFFFFFFF);
    idle();
    rd1(6, "R5 bwe_n high no write");

    // R4: both strobes low -> processor strobe wins, no write
    exp_w.push_back(rm[7]); exp_r.push_back("R4 both strobes read");
    cyc(0, 0, 1, 0, 1, 4'hF, 7, 32'hBAD00007);
    idle();
    rd1(7, "R4 adsc ignored");

    // R1: deselect by ce2, then by ce3_n
    ce2 = 0;
    cyc(1, 0, 1, 0, 1, 4'hF, 8, 32'hBAD00008);
    chk(dq_oe == 0, "R1 deselect ce2", 32'(dq_oe), 32'h0);
    ce2 = 1; ce3_n = 1;
    cyc(0, 1, 1, 1, 1, 4'hF, 9, 32'h0);
    chk(dq_oe == 0, "R1 deselect ce3_n", 32'(dq_oe), 32'h0);
    ce3_n = 0;
    idle();
    rd1(8, "R1 no write when deselected");

    // R6: oe_n combinational
    oe_n = 1;
    cyc(1, 0, 1, 1, 1, 4'hF, 9, 32'h0);
    chk(dq_oe == 0, "R6 oe_n high", 32'(dq_oe), 32'h0);
    #0.5 oe_n = 0;
    #0.1;
    chk(dq_oe == 1 && dq_out === rm[9], "R6 oe_n low drives", dq_out, rm[9]);
    idle();

    // R12: sleep blocks writes
    zz = 1;
    cyc(1, 0, 1, 0, 1, 4'hF, 10, 32'hBAD0000A);
    chk(dq_oe == 0, "R12 sleep quiet", 32'(dq_oe), 32'h0);
    zz = 0;
    idle();
    rd1(10, "R12 contents kept");

    // R5: each lane mapped to its byte
    for (int i = 0; i < 4; i++) begin
      automatic logic [3:0] m = ~(4'b1 << i);
      cyc(1, 0, 1, 1, 0, m, 12, 32'hF3F2F1F0 + 32'(i));
      rwrite(12, 32'hF3F2F1F0 + 32'(i), 1, 0, m);
      idle();
      rd1(12, "R5 lane mapping");
    end

    repeat (3) idle();
    chk(exp_w.size() == 0, "R8 missing reads", 32'(exp_w.size()), 32'h0);
    $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
    $finish;
  end
endmodule